// File: doc/BRIEF.md
# Pipelined SRAM Burst Command Sequencer

The sequencer sits in front of a synchronous pipelined SRAM array. On every rising clock edge it decodes two command inputs and one rate input. A command either starts a new burst from an external address, extends the running burst by one more cycle, or leaves the bus idle. For each active cycle it produces the array address of every beat. A single-rate cycle carries one beat and a double-rate cycle carries two. Alongside the addresses it produces the beat strobes and the read/write direction. One cycle later it produces the enable that lets the data bus be driven for read data.

The two low address bits of each beat come from the starting address and a running beat count. A mode input chooses how they are combined: an XOR-based interleaved order or a modulo-4 linear order. The mode, rate and direction are captured when a burst is loaded, so continue cycles reuse them. The sequencer also watches the read-to-write turnaround. A write issued without two idle cycles after the last read cycle raises a one-cycle flag.

Top module: `bseq_top`

## Requirements
- R1: While reset is asserted and after its release, with no command yet, `beatVld`, `beatWrite`, `busDrive` and `spacingErr` are all 0, and the sequencer is idle.
- R2: Commands use the encoding {loadN,rdWr}. 01 loads a read, 00 loads a write, 10 is a no-operation, and 11 continues the running burst. On a load, `rateSel`=1 selects single rate and 0 selects double rate. On a continue, `rateSel` is ignored.
- R3: In interleaved order (`orderSel`=1), bits [1:0] of a beat address equal the starting bits [1:0] XOR the beat count.
- R4: In linear order (`orderSel`=0), bits [1:0] of a beat address equal (starting bits [1:0] + beat count) mod 4. Bits above bit 1 always equal those of the loaded address.
- R5: A single-rate cycle sets only `beatVld`[0], presents its beat on `arrayAddr0`, and advances the beat count by one.
- R6: A double-rate cycle sets both `beatVld` bits. It presents beat counts n and n+1 on `arrayAddr0` and `arrayAddr1`, and advances the beat count by two.
- R7: Continues beyond the fourth beat wrap the beat count modulo 4, so the address sequence repeats.
- R8: A continue received while idle, after reset or after a no-operation, produces no beats.
- R9: The beat outputs for a command are valid in the cycle after the edge that samples it. `busDrive` is 1 in the cycle that follows a read beat cycle and 0 after a write beat cycle.
- R10: `busDrive` returns to 0 one cycle after a cycle with no beats, for example after a no-operation.
- R11: A write load raises `spacingErr` with its beats when fewer than two no-operation cycles separate it from the last read cycle. Exactly two no-operation cycles raise no flag.
- R12: The order mode is captured at load. Continue cycles use the captured mode, whatever `orderSel` is at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| loadN | input | 1 | 0 loads a new address, 1 continues or idles |
| rdWr | input | 1 | 1 read / 0 write on load; 1 continue / 0 no-op otherwise |
| rateSel | input | 1 | 1 single rate, 0 double rate (sampled on load) |
| orderSel | input | 1 | 1 interleaved, 0 linear burst order (sampled on load) |
| addrIn | input | ADDR_W | Starting address of a new burst |
| arrayAddr0 | output | ADDR_W | Address of the first beat of the cycle |
| arrayAddr1 | output | ADDR_W | Address of the second beat (double rate) |
| beatVld | output | 2 | Beat strobes, bit 0 first beat, bit 1 second beat |
| beatWrite | output | 1 | 1 when the current beats are write beats |
| busDrive | output | 1 | Data bus drive enable for read data |
| spacingErr | output | 1 | Read-to-write turnaround violation pulse |

## Verification
The hardest states to reach are the wrap after a fourth continue and a continue arriving while the order input has changed since the load. Both sit deep inside a burst, so the stimulus table runs single-rate and double-rate reads through long continue chains and flips `orderSel` part way through a burst. The turnaround rule is exercised at its exact boundary. One write follows a read with a single no-op, one follows after exactly two no-ops, and one follows directly after a read.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Command encoding on {loadN, rdWr}
  typedef enum logic [1:0] {
    CMD_WR   = 2'b00,
    CMD_RD   = 2'b01,
    CMD_NOP  = 2'b10,
    CMD_CONT = 2'b11
  } cmd_e;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic       loadBase;  // capture a new starting address and mode
    logic       advance;   // step the beat counter this cycle
    logic       twoStep;   // double rate: step by two
    logic [1:0] laneFire;  // which beat lanes are produced
  } strobe_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int MIN_NOPS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadN,
  input  logic       rdWr,
  input  logic       rateSel,
  output strobe_t    stb,
  output logic [1:0] beatVld,
  output logic       beatWrite,
  output logic       busDrive,
  output logic       spacingErr
);

  localparam int GAP_W = $clog2(MIN_NOPS + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_NOPS);

  cmd_e             cmd;
  logic             activeQ;
  logic             readQ;
  logic             dblQ;
  logic [GAP_W-1:0] gapQ;

  logic isLoad;
  logic isCont;
  logic fire;
  logic dblNow;
  logic rdNow;
  logic turnErr;

  always_comb begin
    cmd     = cmd_e'({loadN, rdWr});
    isLoad  = (cmd == CMD_RD) || (cmd == CMD_WR);
    // a continue counts only inside a burst (R8)
    isCont  = (cmd == CMD_CONT) && activeQ;
    fire    = isLoad || isCont;
    dblNow  = isLoad ? ~rateSel : dblQ;   // rate ignored on continue (R2)
    rdNow   = isLoad ? rdWr     : readQ;
    turnErr = (cmd == CMD_WR) && (gapQ < GAP_MAX);

    stb.loadBase = isLoad;
    stb.advance  = fire;
    stb.twoStep  = dblNow;
    stb.laneFire = {fire & dblNow, fire};
  end

  // burst state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0;
      readQ   <= 1'b0;
      dblQ    <= 1'b0;
    end else begin
      activeQ <= fire;
      if (isLoad) begin
        readQ <= rdWr;
        dblQ  <= ~rateSel;
      end
    end
  end

  // idle cycles seen since the last read cycle, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapQ <= GAP_MAX;
    end else if (fire && rdNow) begin
      gapQ <= '0;
    end else if (!fire && (gapQ < GAP_MAX)) begin
      gapQ <= gapQ + GAP_W'(1);
    end
  end

  // output pipeline
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beatVld    <= 2'b00;
      beatWrite  <= 1'b0;
      busDrive   <= 1'b0;
      spacingErr <= 1'b0;
    end else begin
      beatVld    <= {fire & dblNow, fire};
      beatWrite  <= fire & ~rdNow;
      busDrive   <= beatVld[0] & ~beatWrite;
      spacingErr <= turnErr;
    end
  end

endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MAX_BURST = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  strobe_t                     stb,
  input  logic [ADDR_W-1:0]           addrIn,
  input  logic                        orderSel,
  output logic [1:0][ADDR_W-1:0]      laneAddr
);

  localparam int BEAT_W = $clog2(MAX_BURST);
  localparam int LANES  = 2;

  logic [ADDR_W-1:0] baseQ;
  logic              orderQ;
  logic [BEAT_W-1:0] cntQ;

  logic [ADDR_W-1:0] startAddr;
  logic              orderNow;
  logic [BEAT_W-1:0] curCnt;

  always_comb begin
    startAddr = stb.loadBase ? addrIn   : baseQ;
    orderNow  = stb.loadBase ? orderSel : orderQ;   // mode captured at load (R12)
    curCnt    = stb.loadBase ? '0       : cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ  <= '0;
      orderQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      if (stb.loadBase) begin
        baseQ  <= addrIn;
        orderQ <= orderSel;
      end
      if (stb.advance) begin
        // natural width wrap gives the modulo behaviour (R7)
        cntQ <= curCnt + (stb.twoStep ? BEAT_W'(2) : BEAT_W'(1));
      end
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [BEAT_W-1:0] laneCnt;
    logic [BEAT_W-1:0] laneLo;

    always_comb begin
      laneCnt = curCnt + BEAT_W'(lane);
      laneLo  = orderNow ? (startAddr[BEAT_W-1:0] ^ laneCnt)
                         : (startAddr[BEAT_W-1:0] + laneCnt);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        laneAddr[lane] <= '0;
      end else if (stb.laneFire[lane]) begin
        laneAddr[lane] <= {startAddr[ADDR_W-1:BEAT_W], laneLo};
      end
    end
  end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MAX_BURST = 4,
  parameter int MIN_NOPS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadN,
  input  logic              rdWr,
  input  logic              rateSel,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] arrayAddr0,
  output logic [ADDR_W-1:0] arrayAddr1,
  output logic [1:0]        beatVld,
  output logic              beatWrite,
  output logic              busDrive,
  output logic              spacingErr
);

  strobe_t                 stb;
  logic [1:0][ADDR_W-1:0]  laneAddr;

  bseq_ctrl #(.MIN_NOPS(MIN_NOPS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .loadN      (loadN),
    .rdWr       (rdWr),
    .rateSel    (rateSel),
    .stb        (stb),
    .beatVld    (beatVld),
    .beatWrite  (beatWrite),
    .busDrive   (busDrive),
    .spacingErr (spacingErr)
  );

  bseq_addr #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) addr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .addrIn   (addrIn),
    .orderSel (orderSel),
    .laneAddr (laneAddr)
  );

  assign arrayAddr0 = laneAddr[0];
  assign arrayAddr1 = laneAddr[1];

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       loadN,
  input logic       rdWr,
  input logic [1:0] beatVld,
  input logic       beatWrite,
  input logic       busDrive,
  input logic       spacingErr
);

  // R6: second lane never fires without the first
  assert_lane_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beatVld[1] |-> beatVld[0]);

  // R9: a read beat cycle enables the bus in the next cycle
  assert_drive_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beatVld[0] && !beatWrite) |=> busDrive);

  // R10: no beats means the bus is released one cycle later
  assert_drive_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !beatVld[0] |=> !busDrive);

  // R2: a no-operation yields no beats
  assert_nop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loadN && !rdWr) |=> (beatVld == 2'b00));

  // R8: continue while idle yields no beats
  assert_idle_continue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loadN && rdWr && !beatVld[0]) |=> (beatVld == 2'b00));

  // R11: the turnaround flag only comes with write beats
  assert_err_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spacingErr |-> (beatVld[0] && beatWrite));

endmodule

bind bseq_top bseq_checker chk_i (.*);

// File: tb/bseq_top_tb_top.sv
module bseq_top_tb_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadN = 1'b1;
  logic          rdWr = 1'b0;
  logic          rateSel = 1'b1;
  logic          orderSel = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] arrayAddr0;
  logic [AW-1:0] arrayAddr1;
  logic [1:0]    beatVld;
  logic          beatWrite;
  logic          busDrive;
  logic          spacingErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bseq_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .loadN(loadN), .rdWr(rdWr), .rateSel(rateSel),
    .orderSel(orderSel), .addrIn(addrIn), .arrayAddr0(arrayAddr0),
    .arrayAddr1(arrayAddr1), .beatVld(beatVld), .beatWrite(beatWrite),
    .busDrive(busDrive), .spacingErr(spacingErr)
  );

  typedef struct packed {
    logic          ldN;
    logic          rw;
    logic          rate;
    logic          ord;
    logic [AW-1:0] addr;
    logic [1:0]    vld;
    logic          wr;
    logic [1:0]    lo0;
    logic [1:0]    lo1;
    logic          drv;
    logic          err;
    logic [7:0]    req;
  } vec_t;

  // {ldN,rw,rate,ord, addr, vld,wr,lo0,lo1, drv,err, req}
  localparam vec_t VECS [0:22] = '{
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 0,0, 8'd2 },  // 0  nop             R2
    '{1,1,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 0,0, 8'd8 },  // 1  cont idle       R8
    '{0,1,1,1, 20'h12342, 2'b01,0,2'd2,2'd0, 0,0, 8'd3 },  // 2  rd sgl intl     R3 R5
    '{1,1,0,1, 20'h00000, 2'b01,0,2'd3,2'd0, 1,0, 8'd2 },  // 3  cont, rate=0 ignored R2
    '{1,1,1,1, 20'h00000, 2'b01,0,2'd0,2'd0, 1,0, 8'd3 },  // 4  cont            R3
    '{1,1,1,1, 20'h00000, 2'b01,0,2'd1,2'd0, 1,0, 8'd5 },  // 5  cont            R5
    '{1,1,1,1, 20'h00000, 2'b01,0,2'd2,2'd0, 1,0, 8'd7 },  // 6  cont wraps      R7
    '{0,1,0,0, 20'h00013, 2'b11,0,2'd3,2'd0, 1,0, 8'd4 },  // 7  rd dbl lin      R4 R6
    '{1,1,1,0, 20'h00000, 2'b11,0,2'd1,2'd2, 1,0, 8'd6 },  // 8  cont dbl        R6
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 1,0, 8'd9 },  // 9  nop, drive held R9
    '{0,0,1,1, 20'h00020, 2'b01,1,2'd0,2'd0, 0,1, 8'd11},  // 10 wr after 1 nop  R11
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 0,0, 8'd10},  // 11 nop             R10
    '{0,1,1,0, 20'h00031, 2'b01,0,2'd1,2'd0, 0,0, 8'd4 },  // 12 rd sgl lin      R4
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 1,0, 8'd9 },  // 13 nop             R9
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 0,0, 8'd10},  // 14 nop             R10
    '{0,0,0,1, 20'h00042, 2'b11,1,2'd2,2'd3, 0,0, 8'd11},  // 15 wr 2 nops ok    R11
    '{1,1,1,1, 20'h00000, 2'b11,1,2'd0,2'd1, 0,0, 8'd6 },  // 16 cont dbl wr     R6
    '{0,1,0,1, 20'h00001, 2'b11,0,2'd1,2'd0, 0,0, 8'd3 },  // 17 rd dbl intl     R3
    '{0,0,1,0, 20'h00000, 2'b01,1,2'd0,2'd0, 1,1, 8'd11},  // 18 wr right after rd R11
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 0,0, 8'd10},  // 19 nop             R10
    '{0,1,1,0, 20'h00003, 2'b01,0,2'd3,2'd0, 0,0, 8'd12},  // 20 rd sgl lin      R12
    '{1,1,1,1, 20'h00000, 2'b01,0,2'd0,2'd0, 1,0, 8'd12},  // 21 cont, ord flipped R12
    '{1,0,1,1, 20'h00000, 2'b00,0,2'd0,2'd0, 1,0, 8'd10}   // 22 nop             R10
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-3:0] upper;
    string rq;
    upper = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1", "beatVld in reset", 32'(beatVld), 0);
    check("R1", "busDrive in reset", 32'(busDrive), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "beatVld after reset", 32'(beatVld), 0);
    check("R1", "spacingErr after reset", 32'(spacingErr), 0);
    check("R1", "beatWrite after reset", 32'(beatWrite), 0);

    for (int i = 0; i < 23; i++) begin
      @(negedge clk);
      loadN    = VECS[i].ldN;
      rdWr     = VECS[i].rw;
      rateSel  = VECS[i].rate;
      orderSel = (i == 21) ? 1'b1 : VECS[i].ord;
      addrIn   = VECS[i].addr;
      if (!VECS[i].ldN) upper = VECS[i].addr[AW-1:2];
      @(posedge clk); #2;
      rq = $sformatf("R%0d", VECS[i].req);
      check(rq, $sformatf("vec%0d beatVld", i), 32'(beatVld), 32'(VECS[i].vld));
      check(rq, $sformatf("vec%0d busDrive", i), 32'(busDrive), 32'(VECS[i].drv));
      check(rq, $sformatf("vec%0d spacingErr", i), 32'(spacingErr), 32'(VECS[i].err));
      if (VECS[i].vld[0]) begin
        check(rq, $sformatf("vec%0d beatWrite", i), 32'(beatWrite), 32'(VECS[i].wr));
        check(rq, $sformatf("vec%0d addr0 low", i), 32'(arrayAddr0[1:0]), 32'(VECS[i].lo0));
        check("R4", $sformatf("vec%0d addr0 upper", i), 32'(arrayAddr0[AW-1:2]), 32'(upper));
      end
      if (VECS[i].vld[1]) begin
        check(rq, $sformatf("vec%0d addr1 low", i), 32'(arrayAddr1[1:0]), 32'(VECS[i].lo1));
        check("R4", $sformatf("vec%0d addr1 upper", i), 32'(arrayAddr1[AW-1:2]), 32'(upper));
      end
    end

    // R1: reset in the middle of a read burst clears outputs
    @(negedge clk);
    loadN = 1'b0; rdWr = 1'b1; rateSel = 1'b0; addrIn = 20'h00005;
    @(posedge clk); #2;
    check("R6", "pre-reset double read", 32'(beatVld), 32'h3);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1", "beatVld after mid reset", 32'(beatVld), 0);
    check("R1", "busDrive after mid reset", 32'(busDrive), 0);
    @(negedge clk);
    rst_n = 1'b1; loadN = 1'b1; rdWr = 1'b1;  // continue right after reset
    @(posedge clk); #2;
    check("R8", "continue after reset", 32'(beatVld), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule